// File: doc/BRIEF.md
# Averaging Conversion Burst and Readout Sequencer

This block drives the conversion-start pin of a successive-approximation converter and then asks a byte-stream serial port to read the resulting frame. On an accepted start request it issues a burst of 2^N conversion pulses, each a short high phase followed by a low phase that fills the rest of the conversion cycle. After the last low phase it raises a one-cycle read request together with the number of bytes the frame holds. When the serial port reports that the read is complete, the block pulses frame-ready and returns to idle.

The frame length follows from the output data mode, which the block selects from the request. Any nonzero averaging exponent selects the averaged mode. Without averaging, a request for the common-mode byte selects the differential-plus-common mode that matches the precision; otherwise the plain differential mode is used. The byte count per hardware channel is the differential width rounded up to whole bytes, plus one byte when the common-mode byte is present. This count is then scaled by the channel count. A request that combines averaging with common-mode data is refused, and so is an exponent above 16. Pulse widths are computed from the clock frequency parameter and rounded up to whole clock cycles.

Top module: `sar_burst_readout`

## Requirements
- R1: After reset, cnvOut, busy, rdReq, frameReady and rejected are all low.
- R2: Each conversion pulse holds cnvOut high for ceil(CNV_HIGH_NS × f_clk) cycles. This is 1 cycle at 50 MHz and 10 ns.
- R3: Between pulses, and after the last one, cnvOut stays low for ceil((CYCLE_NS − CNV_TAIL_NS) × f_clk) cycles. This is 24 cycles at 50 MHz and 500 ns.
- R4: An accepted request with exponent N (0 to 16) gives exactly 2^N cnvOut pulses. A single one-cycle rdReq follows, in the cycle after the last low phase ends.
- R5: modeOut encodes 0 as differential only, 1 as 16-bit differential plus common byte, 2 as 24-bit differential plus common byte, 3 as 30-bit averaged and 4 as test pattern. The block selects 3 when N > 0. Otherwise it selects 1 or 2 (prec24 = 0 or 1) if commonReq is set, and 0 if it is not.
- R6: rdBytes equals ceil(bits/8) per channel, where bits is 16 or 24 (by prec24) in modes 0 to 2 and 30 in mode 3. One byte is added in modes 1 and 2. The total is doubled when dualCh = 1.
- R7: A start with N > 0 and commonReq = 1, or with N > 16, produces a one-cycle rejected pulse and no conversion. busy stays low.
- R8: busy is high from the cycle after an accepted start until frameReady. A startReq seen while busy has no effect on the running burst or on its captured mode and byte count.
- R9: frameReady pulses for one cycle in the cycle after rdDone is sampled during the read phase. rdDone has no effect at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request for one burst and readout |
| avgExp | input | 5 | Averaging exponent N |
| commonReq | input | 1 | Include the common-mode byte |
| prec24 | input | 1 | 1 for 24-bit precision, 0 for 16-bit |
| dualCh | input | 1 | 1 for two hardware channels |
| rdDone | input | 1 | Serial port finished the frame read |
| cnvOut | output | 1 | Conversion-start pin |
| rdReq | output | 1 | One-cycle frame read request |
| rdBytes | output | 4 | Frame length in bytes |
| modeOut | output | 3 | Selected output data mode |
| busy | output | 1 | Sequence in progress |
| frameReady | output | 1 | One-cycle frame-complete pulse |
| rejected | output | 1 | One-cycle refusal of a start request |

## Verification
The bench goes after the pulse count at each exponent from 0 to 6. A design with an off-by-one remaining count would issue 2^N ± 1 pulses or raise rdReq one phase early. It measures every high run and every low run, including the final low run before rdReq, which a design that skips the trailing low phase would cut short. It checks each combination of precision, channel count and common byte against the computed byte count and mode, which catches a missing common byte or a wrong averaged width. Directed cases cover refused requests, start requests and rdDone pulses injected mid-burst, and a stray rdDone while idle. Any of these would corrupt a captured configuration or end a frame early in a faulty design.

// File: rtl/sar_burst_pkg.sv
package sar_burst_pkg;

  typedef enum logic [2:0] {
    MODE_DIFF    = 3'd0,
    MODE_D16_C8  = 3'd1,
    MODE_D24_C8  = 3'd2,
    MODE_AVG30   = 3'd3,
    MODE_PATTERN = 3'd4
  } outMode_t;

  typedef struct packed {
    logic load;    // capture request, start first high phase
    logic goLow;   // enter low phase
    logic goHigh;  // start next conversion
  } dpStrobe_t;

  function automatic outMode_t pickMode(logic avgOn, logic wantCommon, logic is24);
    if (avgOn)           return MODE_AVG30;
    else if (wantCommon) return is24 ? MODE_D24_C8 : MODE_D16_C8;
    else                 return MODE_DIFF;
  endfunction

  function automatic logic [3:0] frameBytes(outMode_t mode, logic is24, logic two);
    logic [3:0] perCh;
    case (mode)
      MODE_D16_C8:  perCh = 4'd3;
      MODE_D24_C8:  perCh = 4'd4;
      MODE_AVG30:   perCh = 4'd4;
      MODE_PATTERN: perCh = 4'd4;
      default:      perCh = is24 ? 4'd3 : 4'd2;
    endcase
    return two ? perCh << 1 : perCh;
  endfunction

endpackage

// File: rtl/sar_burst_datapath.sv
module sar_burst_datapath
  import sar_burst_pkg::*;
#(
  parameter int HIGH_CYC = 1,
  parameter int LOW_CYC  = 24,
  parameter int EXP_W    = 5,
  parameter int MAX_EXP  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [EXP_W-1:0] avgExp,
  input  logic             commonReq,
  input  logic             prec24,
  input  logic             dualCh,
  output logic             phaseDone,
  output logic             lastConv,
  output outMode_t         modeSel,
  output logic [3:0]       byteCount
);
  localparam int PH_MAX = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CNT_W  = MAX_EXP + 1;

  logic [PH_W-1:0]  phaseCnt;
  logic [CNT_W-1:0] convLeft;
  outMode_t         nextMode;

  assign nextMode  = pickMode(avgExp != '0, commonReq, prec24);
  assign phaseDone = (phaseCnt == '0);
  assign lastConv  = (convLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      convLeft  <= '0;
      modeSel   <= MODE_DIFF;
      byteCount <= '0;
    end else if (strobe.load) begin
      phaseCnt  <= PH_W'(HIGH_CYC - 1);
      convLeft  <= (CNT_W'(1) << avgExp) - CNT_W'(1);
      modeSel   <= nextMode;
      byteCount <= frameBytes(nextMode, prec24, dualCh);
    end else if (strobe.goLow) begin
      phaseCnt  <= PH_W'(LOW_CYC - 1);
    end else if (strobe.goHigh) begin
      phaseCnt  <= PH_W'(HIGH_CYC - 1);
      convLeft  <= convLeft - CNT_W'(1);
    end else if (!phaseDone) begin
      phaseCnt  <= phaseCnt - PH_W'(1);
    end
  end

  // R4: a new conversion is only started while conversions remain
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.goHigh |-> !lastConv);

  // R5: averaged mode always comes with a four-byte-per-channel frame
  p_avg_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AVG30) |-> (byteCount == 4'd4 || byteCount == 4'd8));

  // R8: captured configuration holds until the next load
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.load) |-> $stable(byteCount) && $stable(modeSel));
endmodule

// File: rtl/sar_burst_ctrl.sv
module sar_burst_ctrl
  import sar_burst_pkg::*;
#(
  parameter int EXP_W   = 5,
  parameter int MAX_EXP = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [EXP_W-1:0] avgExp,
  input  logic             commonReq,
  input  logic             rdDone,
  input  logic             phaseDone,
  input  logic             lastConv,
  output dpStrobe_t        strobe,
  output logic             cnvOut,
  output logic             rdReq,
  output logic             frameReady,
  output logic             busy,
  output logic             rejected
);
  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_LOW, S_READ} state_t;

  state_t stateQ, stateD;
  logic   badReq;

  assign badReq = (avgExp > EXP_W'(MAX_EXP)) || ((avgExp != '0) && commonReq);
  assign cnvOut = (stateQ == S_HIGH);
  assign busy   = (stateQ != S_IDLE);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      S_IDLE: if (startReq && !badReq) begin
        strobe.load = 1'b1;
        stateD      = S_HIGH;
      end
      S_HIGH: if (phaseDone) begin
        strobe.goLow = 1'b1;
        stateD       = S_LOW;
      end
      S_LOW: if (phaseDone) begin
        if (lastConv) stateD = S_READ;
        else begin
          strobe.goHigh = 1'b1;
          stateD        = S_HIGH;
        end
      end
      S_READ: if (rdDone) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      rdReq      <= 1'b0;
      frameReady <= 1'b0;
      rejected   <= 1'b0;
    end else begin
      stateQ     <= stateD;
      rdReq      <= (stateQ == S_LOW) && (stateD == S_READ);
      frameReady <= (stateQ == S_READ) && rdDone;
      rejected   <= (stateQ == S_IDLE) && startReq && badReq;
    end
  end

  // R4: read request is a single-cycle pulse
  p_rdreq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R9: frame-ready only follows a completion from the serial port
  p_frame_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |-> $past(rdDone));

  // R8: busy drops only together with frame-ready
  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> frameReady);

  // R7: a refused request never starts a sequence
  p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> !busy && !cnvOut);
endmodule

// File: rtl/sar_burst_readout.sv
module sar_burst_readout
  import sar_burst_pkg::*;
#(
  parameter int CLK_FREQ_KHZ = 50_000,
  parameter int CNV_HIGH_NS  = 10,
  parameter int CYCLE_NS     = 500,
  parameter int CNV_TAIL_NS  = 20,
  parameter int EXP_W        = 5,
  parameter int MAX_EXP      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [EXP_W-1:0] avgExp,
  input  logic             commonReq,
  input  logic             prec24,
  input  logic             dualCh,
  input  logic             rdDone,
  output logic             cnvOut,
  output logic             rdReq,
  output logic [3:0]       rdBytes,
  output logic [2:0]       modeOut,
  output logic             busy,
  output logic             frameReady,
  output logic             rejected
);
  localparam longint NS_PER_KCYC = 64'd1_000_000;
  localparam int HIGH_CYC = int'((longint'(CNV_HIGH_NS) * CLK_FREQ_KHZ + NS_PER_KCYC - 1) / NS_PER_KCYC);
  localparam int LOW_CYC  = int'((longint'(CYCLE_NS - CNV_TAIL_NS) * CLK_FREQ_KHZ + NS_PER_KCYC - 1) / NS_PER_KCYC);

  dpStrobe_t strobe;
  logic      phaseDone, lastConv;
  outMode_t  modeSel;

  sar_burst_ctrl #(.EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .avgExp(avgExp),
    .commonReq(commonReq), .rdDone(rdDone), .phaseDone(phaseDone),
    .lastConv(lastConv), .strobe(strobe), .cnvOut(cnvOut), .rdReq(rdReq),
    .frameReady(frameReady), .busy(busy), .rejected(rejected)
  );

  sar_burst_datapath #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC),
                       .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .avgExp(avgExp),
    .commonReq(commonReq), .prec24(prec24), .dualCh(dualCh),
    .phaseDone(phaseDone), .lastConv(lastConv), .modeSel(modeSel),
    .byteCount(rdBytes)
  );

  assign modeOut = modeSel;
endmodule

// File: tb/sar_burst_readout_bench.sv
`timescale 1ns/1ps
module sar_burst_readout_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 0, commonReq = 0, prec24 = 0, dualCh = 0, rdDone = 0;
  logic [4:0] avgExp = '0;
  logic cnvOut, rdReq, busy, frameReady, rejected;
  logic [3:0] rdBytes;
  logic [2:0] modeOut;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sar_burst_readout u_sar_burst_readout (
    .clk(clk), .rstN(rstN), .startReq(startReq), .avgExp(avgExp),
    .commonReq(commonReq), .prec24(prec24), .dualCh(dualCh), .rdDone(rdDone),
    .cnvOut(cnvOut), .rdReq(rdReq), .rdBytes(rdBytes), .modeOut(modeOut),
    .busy(busy), .frameReady(frameReady), .rejected(rejected)
  );

  function automatic int ceilCyc(int ns);
    return (ns * 50 + 999) / 1000;  // 50 MHz clock
  endfunction

  localparam int EXP_HIGH = 1;   // ceil(10 ns at 50 MHz)
  localparam int EXP_LOW  = 24;  // ceil(480 ns at 50 MHz)

  function automatic int expMode(int n, bit c, bit p);
    if (n > 0) return 3;
    if (c) return p ? 2 : 1;
    return 0;
  endfunction

  function automatic int expBytes(int n, bit c, bit p, bit d);
    int bits, b;
    bits = (n > 0) ? 30 : (p ? 24 : 16);
    b = (bits + 7) / 8 + ((n == 0 && c) ? 1 : 0);
    return d ? 2 * b : b;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doFrame(int n, bit c, bit p, bit d, int injectAt);
    int rises = 0, badHigh = 0, badLow = 0, busyLow = 0, run = 0, samples = 0;
    bit prevCnv = 1'b1, gotReq = 1'b0;
    @(negedge clk);
    avgExp = 5'(n); commonReq = c; prec24 = p; dualCh = d; startReq = 1;
    @(negedge clk);
    startReq = 0;
    while (samples < 5000) begin
      samples++;
      if (injectAt > 0 && samples == injectAt) begin
        startReq = 1; rdDone = 1; avgExp = 0; commonReq = !c; prec24 = !p; dualCh = !d;
      end else begin
        startReq = 0; rdDone = 0;
      end
      if (!busy) busyLow++;
      if (rdReq) begin
        gotReq = 1;
        if (prevCnv || run != EXP_LOW) badLow++;
        break;
      end
      if (cnvOut && !prevCnv) rises++;
      if (samples == 1 && cnvOut) rises++;
      if (cnvOut == prevCnv) run++;
      else begin
        if (prevCnv && run != EXP_HIGH) badHigh++;
        if (!prevCnv && run != EXP_LOW) badLow++;
        run = 1;
      end
      prevCnv = cnvOut;
      @(negedge clk);
    end
    chk(gotReq, "R4 rdReq reached", gotReq, 1);
    chk(rises == (1 << n), "R4 pulse count", rises, 1 << n);
    chk(badHigh == 0, "R2 high width", badHigh, 0);
    chk(badLow == 0, "R3 low width", badLow, 0);
    chk(busyLow == 0, "R8 busy during burst", busyLow, 0);
    chk(int'(modeOut) == expMode(n, c, p), "R5 mode", modeOut, expMode(n, c, p));
    chk(int'(rdBytes) == expBytes(n, c, p, d), "R6 bytes", rdBytes, expBytes(n, c, p, d));
    @(negedge clk);
    chk(!rdReq && busy && !frameReady, "R4 rdReq single", rdReq, 0);
    rdDone = 1;
    @(negedge clk);
    rdDone = 0;
    chk(frameReady && !busy, "R9 frameReady after rdDone", frameReady, 1);
    @(negedge clk);
    chk(!frameReady, "R9 frameReady one cycle", frameReady, 0);
  endtask

  task automatic doReject(int n, bit c);
    int stray = 0;
    @(negedge clk);
    avgExp = 5'(n); commonReq = c; startReq = 1;
    @(negedge clk);
    startReq = 0;
    chk(rejected && !busy, "R7 rejected pulse", rejected, 1);
    for (int i = 0; i < 30; i++) begin
      if (cnvOut || busy || rdReq) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R7 no conversion", stray, 0);
    chk(!rejected, "R7 pulse ends", rejected, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    chk(ceilCyc(10) == EXP_HIGH && ceilCyc(480) == EXP_LOW, "R2 R3 bench timing", ceilCyc(480), EXP_LOW);
    repeat (3) @(negedge clk);
    chk(!cnvOut && !busy && !rdReq && !frameReady && !rejected, "R1 in reset", cnvOut, 0);
    rstN = 1;
    @(negedge clk);
    chk(!cnvOut && !busy && !rdReq && !frameReady && !rejected, "R1 after reset", busy, 0);

    // R9: stray rdDone while idle
    rdDone = 1; @(negedge clk); rdDone = 0; @(negedge clk);
    chk(!frameReady && !busy, "R9 idle rdDone ignored", frameReady, 0);

    // directed corners
    doFrame(0, 0, 0, 0, 0);
    doFrame(0, 1, 1, 1, 0);
    doFrame(6, 0, 1, 1, 0);
    doFrame(3, 0, 0, 0, 30);   // R8 inject start and rdDone mid-burst
    doReject(2, 1);
    doReject(17, 0);

    for (int k = 0; k < 24; k++) begin
      int n; bit c, p, d;
      n = int'($urandom_range(0, 5));
      p = 1'($urandom_range(0, 1));
      d = 1'($urandom_range(0, 1));
      c = (n == 0) ? 1'($urandom_range(0, 1)) : 1'b0;
      if (n > 0 && $urandom_range(0, 7) == 0) doReject(n, 1);
      else doFrame(n, c, p, d, (k % 4 == 0) ? 5 : 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule